// File: doc/BRIEF.md
# Block-Wide Reconvergence Stack

This block keeps the control-flow state of one thread block that is spread over several warps. A single stack serves the whole block. Each entry holds a PC to run, the PC at which its paths rejoin, and one active bit per thread of the block. The top entry names the instruction and the set of threads that a downstream compactor packs into dynamic warps.

Branch outcomes and reconvergence points come in as events. Each event is applied only once every live warp has reported arrival at that point, so the order in which the scheduler ran the warps has no effect on the result. A divergent branch turns the current top into the rejoin entry and pushes the not-taken path, then the taken path. Reaching an entry's rejoin PC pops it. After each release, a single-cycle valid pulse presents the new top to the compactor.

Top module: `simt_block_stack`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0 and `out_mask` is 0. A cycle with `init_valid` high loads a single base entry with `init_pc` and `init_mask` and a rejoin PC of all ones. It clears the overflow flag and any pending event or arrival. It marks live every warp that has at least one set bit in `init_mask`, where warp w owns thread bits w*WARP_LANES to w*WARP_LANES+WARP_LANES-1. No `out_valid` follows it.
- R2: An event is latched when `ev_valid` is high. It takes effect only in the cycle in which every live warp has arrived: bit w of `arrive` reports warp w, and arrivals accumulate across cycles. `out_valid` rises in the cycle after the clock edge that samples the last live arrival, never earlier.
- R3: A branch event (`ev_branch`=1) whose effective taken set is empty sets the top PC to `ev_fallthru`. One whose effective taken set covers the whole top mask sets the top PC to `ev_target`. In both cases the mask is unchanged and nothing is pushed.
- R4: A divergent branch sets the top PC to `ev_rpc`, then pushes {`ev_fallthru`, `ev_rpc`, not-taken threads}, then {`ev_target`, `ev_rpc`, taken threads}. The taken path becomes the top.
- R5: A reconvergence event (`ev_branch`=0) whose `ev_pc` equals the top rejoin PC, with more than one entry on the stack, pops the top entry. Otherwise the event only rewrites the top PC to `ev_pc`.
- R6: A high bit in `exit_warp` removes that warp from the live set. Later arrivals from that warp are ignored. A barrier that already holds every remaining live warp releases one cycle later. If no warp is live, nothing is released.
- R7: A divergent branch that needs two entries while fewer than two are free leaves the stack unchanged and sets `overflow`. `overflow` stays set until the next init.
- R8: `out_valid` is high for exactly one cycle per release.
- R9: Taken bits outside the top mask are ignored. The effective taken set is `ev_taken` ANDed with the top mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Start a new thread block |
| init_pc | input | PC_W | First PC of the block |
| init_mask | input | NUM_WARPS*WARP_LANES | Threads present at start |
| arrive | input | NUM_WARPS | Per-warp arrival at the current barrier point |
| exit_warp | input | NUM_WARPS | Per-warp exit notice |
| ev_valid | input | 1 | Event descriptor present |
| ev_branch | input | 1 | 1 = branch resolution, 0 = reconvergence point |
| ev_taken | input | NUM_WARPS*WARP_LANES | Threads that took the branch |
| ev_target | input | PC_W | Taken target PC |
| ev_fallthru | input | PC_W | Not-taken PC |
| ev_rpc | input | PC_W | Rejoin PC for a divergent branch |
| ev_pc | input | PC_W | PC reached by a reconvergence event |
| out_valid | output | 1 | One-cycle pulse after each release |
| out_pc | output | PC_W | PC of the top entry |
| out_mask | output | NUM_WARPS*WARP_LANES | Active threads of the top entry |
| overflow | output | 1 | Sticky flag for a refused push |

## Verification
The checker watches four things on every cycle: the stack fill level stays within its bounds, the overflow flag is sticky, the top entry holds still when a push is refused, and there is no release while no warp is live or right after an init. Whether the barrier waits for the last live warp under every arrival order, and whether split, pop and rewrite leave the right PCs and masks, can only be shown by the bench's scenarios. These are directed sequences for exits, overflow and out-of-mask taken bits, plus random events checked against a reference stack model in the bench.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
   typedef enum logic [1:0] {
      STK_HOLD  = 2'd0,
      STK_SETPC = 2'd1,
      STK_SPLIT = 2'd2,
      STK_POP   = 2'd3
   } stk_op_e;
endpackage

// File: rtl/sbs_barrier.sv
module sbs_barrier #(
   parameter int NUM_WARPS  = 3,
   parameter int WARP_LANES = 4,
   localparam int THREADS   = NUM_WARPS * WARP_LANES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_valid,
   input  logic [THREADS-1:0]   init_mask,
   input  logic [NUM_WARPS-1:0] arrive,
   input  logic [NUM_WARPS-1:0] exit_warp,
   input  logic                 ev_valid,
   output logic                 release_o,
   output logic [NUM_WARPS-1:0] live_o
);
   logic [NUM_WARPS-1:0] live_q, arrived_q, init_live;
   logic                 pend_q;
   logic                 all_in;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_live
      assign init_live[w] = |init_mask[w*WARP_LANES +: WARP_LANES];
   end

   assign all_in    = (((arrived_q | arrive) & live_q) == live_q);
   assign release_o = (pend_q | ev_valid) & (|live_q) & all_in & ~init_valid;
   assign live_o    = live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q    <= '0;
         arrived_q <= '0;
         pend_q    <= 1'b0;
      end else if (init_valid) begin
         live_q    <= init_live;
         arrived_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         live_q <= live_q & ~exit_warp;
         if (release_o) begin
            arrived_q <= '0;
            pend_q    <= 1'b0;
         end else begin
            arrived_q <= (arrived_q | arrive) & live_q;
            pend_q    <= pend_q | ev_valid;
         end
      end
   end
endmodule

// File: rtl/sbs_decode.sv
module sbs_decode
   import simt_stack_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int THREADS = 12,
   parameter int CNT_W   = 4
) (
   input  logic               ev_branch,
   input  logic [THREADS-1:0] ev_taken,
   input  logic [PC_W-1:0]    ev_target,
   input  logic [PC_W-1:0]    ev_fallthru,
   input  logic [PC_W-1:0]    ev_pc,
   input  logic [THREADS-1:0] top_mask,
   input  logic [PC_W-1:0]    top_rpc,
   input  logic [CNT_W-1:0]   depth,
   output stk_op_e            op,
   output logic [PC_W-1:0]    new_pc,
   output logic [THREADS-1:0] taken_mask,
   output logic [THREADS-1:0] fall_mask
);
   always_comb begin
      taken_mask = ev_taken & top_mask;
      fall_mask  = top_mask & ~taken_mask;
      op         = STK_SETPC;
      new_pc     = ev_pc;
      if (ev_branch) begin
         if (taken_mask == '0) begin
            new_pc = ev_fallthru;
         end else if (fall_mask == '0) begin
            new_pc = ev_target;
         end else begin
            op = STK_SPLIT;
         end
      end else if ((ev_pc == top_rpc) && (depth > CNT_W'(1))) begin
         op = STK_POP;
      end
   end
endmodule

// File: rtl/sbs_stack.sv
module sbs_stack
   import simt_stack_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int THREADS = 12,
   parameter int DEPTH   = 8,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_valid,
   input  logic [PC_W-1:0]    init_pc,
   input  logic [THREADS-1:0] init_mask,
   input  stk_op_e            op,
   input  logic [PC_W-1:0]    new_pc,
   input  logic [PC_W-1:0]    split_rpc,
   input  logic [PC_W-1:0]    lo_pc,
   input  logic [THREADS-1:0] lo_mask,
   input  logic [PC_W-1:0]    hi_pc,
   input  logic [THREADS-1:0] hi_mask,
   output logic [PC_W-1:0]    top_pc,
   output logic [PC_W-1:0]    top_rpc,
   output logic [THREADS-1:0] top_mask,
   output logic [CNT_W-1:0]   depth,
   output logic               overflow
);
   logic [PC_W-1:0]    pc_q   [DEPTH];
   logic [PC_W-1:0]    rpc_q  [DEPTH];
   logic [THREADS-1:0] mask_q [DEPTH];
   logic [CNT_W-1:0]   cnt_q;
   logic               ovf_q;
   logic [IDX_W-1:0]   top_idx;
   logic               fits;

   assign top_idx  = IDX_W'(cnt_q - CNT_W'(1));
   assign fits     = (int'(cnt_q) + 2) <= DEPTH;
   assign top_pc   = pc_q[top_idx];
   assign top_rpc  = rpc_q[top_idx];
   assign top_mask = mask_q[top_idx];
   assign depth    = cnt_q;
   assign overflow = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            pc_q[i]   <= '0;
            rpc_q[i]  <= (i == 0) ? '1 : '0;
            mask_q[i] <= '0;
         end
         cnt_q <= CNT_W'(1);
         ovf_q <= 1'b0;
      end else if (init_valid) begin
         pc_q[0]   <= init_pc;
         rpc_q[0]  <= '1;
         mask_q[0] <= init_mask;
         cnt_q     <= CNT_W'(1);
         ovf_q     <= 1'b0;
      end else begin
         case (op)
            STK_SETPC: pc_q[top_idx] <= new_pc;
            STK_POP:   cnt_q <= cnt_q - CNT_W'(1);
            STK_SPLIT: begin
               if (fits) begin
                  for (int i = 0; i < DEPTH; i++) begin
                     if (int'(cnt_q) == i + 1) begin
                        pc_q[i] <= split_rpc;
                     end
                     if (int'(cnt_q) == i) begin
                        pc_q[i]   <= lo_pc;
                        rpc_q[i]  <= split_rpc;
                        mask_q[i] <= lo_mask;
                     end
                     if (int'(cnt_q) + 1 == i) begin
                        pc_q[i]   <= hi_pc;
                        rpc_q[i]  <= split_rpc;
                        mask_q[i] <= hi_mask;
                     end
                  end
                  cnt_q <= cnt_q + CNT_W'(2);
               end else begin
                  ovf_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/simt_block_stack.sv
module simt_block_stack
   import simt_stack_pkg::*;
#(
   parameter int NUM_WARPS  = 3,
   parameter int WARP_LANES = 4,
   parameter int PC_W       = 16,
   parameter int DEPTH      = 8,
   localparam int THREADS   = NUM_WARPS * WARP_LANES,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_valid,
   input  logic [PC_W-1:0]      init_pc,
   input  logic [THREADS-1:0]   init_mask,
   input  logic [NUM_WARPS-1:0] arrive,
   input  logic [NUM_WARPS-1:0] exit_warp,
   input  logic                 ev_valid,
   input  logic                 ev_branch,
   input  logic [THREADS-1:0]   ev_taken,
   input  logic [PC_W-1:0]      ev_target,
   input  logic [PC_W-1:0]      ev_fallthru,
   input  logic [PC_W-1:0]      ev_rpc,
   input  logic [PC_W-1:0]      ev_pc,
   output logic                 out_valid,
   output logic [PC_W-1:0]      out_pc,
   output logic [THREADS-1:0]   out_mask,
   output logic                 overflow
);
   if (DEPTH < 3) begin : g_bad_depth
      $error("simt_block_stack: DEPTH must be at least 3");
   end
   if (NUM_WARPS < 1 || WARP_LANES < 1) begin : g_bad_shape
      $error("simt_block_stack: NUM_WARPS and WARP_LANES must be positive");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("simt_block_stack: PC_W must be at least 2");
   end

   logic                 ev_branch_q;
   logic [THREADS-1:0]   ev_taken_q;
   logic [PC_W-1:0]      ev_target_q, ev_fallthru_q, ev_rpc_q, ev_pc_q;
   logic                 s_branch;
   logic [THREADS-1:0]   s_taken;
   logic [PC_W-1:0]      s_target, s_fallthru, s_rpc, s_pc;
   logic                 rel;
   logic [NUM_WARPS-1:0] live_w;
   logic [CNT_W-1:0]     depth_w;
   logic [PC_W-1:0]      top_rpc_w, dec_pc;
   logic [THREADS-1:0]   top_mask_w, taken_m, fall_m;
   stk_op_e              dec_op, op_eff;
   logic                 valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_branch_q   <= 1'b0;
         ev_taken_q    <= '0;
         ev_target_q   <= '0;
         ev_fallthru_q <= '0;
         ev_rpc_q      <= '0;
         ev_pc_q       <= '0;
      end else if (ev_valid) begin
         ev_branch_q   <= ev_branch;
         ev_taken_q    <= ev_taken;
         ev_target_q   <= ev_target;
         ev_fallthru_q <= ev_fallthru;
         ev_rpc_q      <= ev_rpc;
         ev_pc_q       <= ev_pc;
      end
   end

   assign s_branch   = ev_valid ? ev_branch   : ev_branch_q;
   assign s_taken    = ev_valid ? ev_taken    : ev_taken_q;
   assign s_target   = ev_valid ? ev_target   : ev_target_q;
   assign s_fallthru = ev_valid ? ev_fallthru : ev_fallthru_q;
   assign s_rpc      = ev_valid ? ev_rpc      : ev_rpc_q;
   assign s_pc       = ev_valid ? ev_pc       : ev_pc_q;

   sbs_barrier #(.NUM_WARPS(NUM_WARPS), .WARP_LANES(WARP_LANES)) i_barrier (
      .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_mask(init_mask),
      .arrive(arrive), .exit_warp(exit_warp), .ev_valid(ev_valid),
      .release_o(rel), .live_o(live_w)
   );

   sbs_decode #(.PC_W(PC_W), .THREADS(THREADS), .CNT_W(CNT_W)) i_decode (
      .ev_branch(s_branch), .ev_taken(s_taken), .ev_target(s_target),
      .ev_fallthru(s_fallthru), .ev_pc(s_pc), .top_mask(top_mask_w),
      .top_rpc(top_rpc_w), .depth(depth_w), .op(dec_op), .new_pc(dec_pc),
      .taken_mask(taken_m), .fall_mask(fall_m)
   );

   assign op_eff = rel ? dec_op : STK_HOLD;

   sbs_stack #(.PC_W(PC_W), .THREADS(THREADS), .DEPTH(DEPTH)) i_stack (
      .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_pc(init_pc),
      .init_mask(init_mask), .op(op_eff), .new_pc(dec_pc), .split_rpc(s_rpc),
      .lo_pc(s_fallthru), .lo_mask(fall_m), .hi_pc(s_target), .hi_mask(taken_m),
      .top_pc(out_pc), .top_rpc(top_rpc_w), .top_mask(top_mask_w),
      .depth(depth_w), .overflow(overflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= rel;
   end

   assign out_valid = valid_q;
   assign out_mask  = top_mask_w;
endmodule

// File: rtl/simt_block_stack_chk.sv
module simt_block_stack_chk #(
   parameter int NUM_WARPS = 3,
   parameter int THREADS   = 12,
   parameter int PC_W      = 16,
   parameter int DEPTH     = 8,
   parameter int CNT_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 init_valid,
   input logic                 out_valid,
   input logic [PC_W-1:0]      out_pc,
   input logic [THREADS-1:0]   out_mask,
   input logic                 overflow,
   input logic [NUM_WARPS-1:0] live,
   input logic [CNT_W-1:0]     depth
);
   // R7: overflow stays set until an init
   a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !init_valid) |=> overflow);

   // R7: a refused push leaves the top entry untouched
   a_r7_refused_push_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> ($stable(out_pc) && $stable(out_mask)));

   // R6: with no live warp the barrier never releases
   a_r6_no_release_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (live == '0) |=> !out_valid);

   // R1: init is never followed by a release pulse
   a_r1_no_pulse_after_init: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_valid) |-> !out_valid);

   // R4: fill level stays within 1..DEPTH
   a_r4_depth_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (depth >= CNT_W'(1)) && (int'(depth) <= DEPTH));
endmodule

bind simt_block_stack simt_block_stack_chk #(
   .NUM_WARPS(NUM_WARPS), .THREADS(THREADS), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .out_valid(out_valid),
   .out_pc(out_pc), .out_mask(out_mask), .overflow(overflow),
   .live(live_w), .depth(depth_w)
);

// File: tb/test_simt_block_stack.sv
module test_simt_block_stack;
   localparam int NW = 3, LN = 4, TH = NW * LN, PW = 16, DP = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, init_valid, ev_valid, ev_branch;
   logic [PW-1:0] init_pc, ev_target, ev_fallthru, ev_rpc, ev_pc;
   logic [TH-1:0] init_mask, ev_taken;
   logic [NW-1:0] arrive, exit_warp;
   logic          out_valid, overflow;
   logic [PW-1:0] out_pc;
   logic [TH-1:0] out_mask;

   simt_block_stack #(.NUM_WARPS(NW), .WARP_LANES(LN), .PC_W(PW), .DEPTH(DP)) i_simt_block_stack (
      .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_pc(init_pc),
      .init_mask(init_mask), .arrive(arrive), .exit_warp(exit_warp),
      .ev_valid(ev_valid), .ev_branch(ev_branch), .ev_taken(ev_taken),
      .ev_target(ev_target), .ev_fallthru(ev_fallthru), .ev_rpc(ev_rpc),
      .ev_pc(ev_pc), .out_valid(out_valid), .out_pc(out_pc),
      .out_mask(out_mask), .overflow(overflow)
   );

   int total = 0, bad = 0;

   logic [PW-1:0] m_pc [DP];
   logic [PW-1:0] m_rpc[DP];
   logic [TH-1:0] m_mask[DP];
   int            m_cnt;
   bit            m_ovf;
   logic [NW-1:0] m_live;
   logic          p_br;
   logic [TH-1:0] p_tk;
   logic [PW-1:0] p_tgt, p_ft, p_rpc, p_pc;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic m_init(input logic [PW-1:0] pc, input logic [TH-1:0] mask);
      m_cnt = 1; m_pc[0] = pc; m_rpc[0] = '1; m_mask[0] = mask; m_ovf = 0;
      for (int w = 0; w < NW; w++) m_live[w] = |mask[w*LN +: LN];
   endtask

   task automatic m_apply();
      int t;
      logic [TH-1:0] tk, fl;
      t  = m_cnt - 1;
      tk = p_tk & m_mask[t];
      fl = m_mask[t] & ~tk;
      if (p_br) begin
         if (tk == '0) m_pc[t] = p_ft;
         else if (fl == '0) m_pc[t] = p_tgt;
         else if (m_cnt + 2 > DP) m_ovf = 1;
         else begin
            m_pc[t] = p_rpc;
            m_pc[t+1] = p_ft;  m_rpc[t+1] = p_rpc; m_mask[t+1] = fl;
            m_pc[t+2] = p_tgt; m_rpc[t+2] = p_rpc; m_mask[t+2] = tk;
            m_cnt += 2;
         end
      end else if (p_pc == m_rpc[t] && m_cnt > 1) m_cnt--;
      else m_pc[t] = p_pc;
   endtask

   task automatic chk_top(input string req);
      chk({req, " pc"}, 64'(out_pc), 64'(m_pc[m_cnt-1]));
      chk({req, " mask"}, 64'(out_mask), 64'(m_mask[m_cnt-1]));
      chk({req, " overflow"}, 64'(overflow), 64'(m_ovf));
   endtask

   task automatic do_init(input logic [PW-1:0] pc, input logic [TH-1:0] mask);
      init_valid = 1; init_pc = pc; init_mask = mask;
      tick();
      init_valid = 0;
      m_init(pc, mask);
      chk("R1 no pulse after init", 64'(out_valid), 64'(0));
      chk_top("R1 init load");
   endtask

   task automatic post_event(input logic br, input logic [TH-1:0] tk, input logic [PW-1:0] tgt,
                             input logic [PW-1:0] ft, input logic [PW-1:0] rpc, input logic [PW-1:0] pc);
      p_br = br; p_tk = tk; p_tgt = tgt; p_ft = ft; p_rpc = rpc; p_pc = pc;
      ev_valid = 1; ev_branch = br; ev_taken = tk; ev_target = tgt;
      ev_fallthru = ft; ev_rpc = rpc; ev_pc = pc;
      tick();
      ev_valid = 0;
      chk("R2 event alone does not release", 64'(out_valid), 64'(0));
   endtask

   task automatic arrive_all(input string req, input int off);
      int nlive, seen;
      nlive = 0; seen = 0;
      for (int w = 0; w < NW; w++) if (m_live[w]) nlive++;
      for (int k = 0; k < NW; k++) begin
         int w;
         w = (off + k) % NW;
         if (!m_live[w]) continue;
         arrive = NW'(1) << w;
         tick();
         arrive = '0;
         seen++;
         if (seen < nlive) chk("R2 no release before last live warp", 64'(out_valid), 64'(0));
         else begin
            m_apply();
            chk("R2 release pulse after last arrival", 64'(out_valid), 64'(1));
            chk_top(req);
         end
      end
      tick();
      chk("R8 pulse lasts one cycle", 64'(out_valid), 64'(0));
   endtask

   initial begin
      #(20ns * 100000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20110214));
      rst_n = 0; init_valid = 0; init_pc = '0; init_mask = '0;
      arrive = '0; exit_warp = '0; ev_valid = 0; ev_branch = 0;
      ev_taken = '0; ev_target = '0; ev_fallthru = '0; ev_rpc = '0; ev_pc = '0;
      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      tick();
      chk("R1 reset out_valid", 64'(out_valid), 64'(0));
      chk("R1 reset overflow", 64'(overflow), 64'(0));
      chk("R1 reset mask", 64'(out_mask), 64'(0));

      // R3 uniform branches
      do_init(16'h0010, 12'hfff);
      post_event(1, 12'hfff, 16'h0020, 16'h0014, 16'h0030, 16'h0);
      arrive_all("R3 all taken", 0);
      post_event(1, 12'h000, 16'h0040, 16'h0024, 16'h0030, 16'h0);
      arrive_all("R3 none taken", 2);

      // R4 divergent split, R9 out-of-mask taken bits, R5 rewrite and pops
      post_event(1, 12'h0f0, 16'h0040, 16'h0030, 16'h0050, 16'h0);
      arrive_all("R4 split taken path on top", 1);
      post_event(1, 12'hf0f, 16'h0070, 16'h0044, 16'h0060, 16'h0);
      arrive_all("R9 taken bits outside mask give not-taken", 0);
      post_event(1, 12'h1f0, 16'h0048, 16'h0046, 16'h0060, 16'h0);
      arrive_all("R9 masked taken covers mask", 2);
      post_event(0, 12'h0, 16'h0, 16'h0, 16'h0, 16'h0049);
      arrive_all("R5 non-matching pc rewrites top", 1);
      post_event(0, 12'h0, 16'h0, 16'h0, 16'h0, 16'h0050);
      arrive_all("R4 pop to not-taken path", 0);
      chk("R4 not-taken mask", 64'(out_mask), 64'(12'hf0f));
      post_event(0, 12'h0, 16'h0, 16'h0, 16'h0, 16'h0050);
      arrive_all("R4 pop to rejoin entry", 2);
      chk("R4 rejoin mask", 64'(out_mask), 64'(12'hfff));
      post_event(0, 12'h0, 16'h0, 16'h0, 16'h0, 16'h0060);
      arrive_all("R5 base entry not popped", 1);

      // R7 overflow with DEPTH 6
      do_init(16'h0200, 12'hfff);
      post_event(1, 12'h00f, 16'h0210, 16'h0220, 16'h0230, 16'h0);
      arrive_all("R7 first split", 0);
      post_event(1, 12'h003, 16'h0240, 16'h0250, 16'h0260, 16'h0);
      arrive_all("R7 second split", 1);
      post_event(1, 12'h001, 16'h0270, 16'h0280, 16'h0290, 16'h0);
      arrive_all("R7 refused split", 2);
      chk("R7 overflow set", 64'(overflow), 64'(1));
      post_event(1, 12'h000, 16'h0270, 16'h0244, 16'h0290, 16'h0);
      arrive_all("R7 overflow sticky", 0);
      do_init(16'h0300, 12'hfff);

      // R6 exits
      exit_warp = 3'b100; tick(); exit_warp = '0; m_live[2] = 0;
      post_event(1, 12'hfff, 16'h0110, 16'h0104, 16'h0120, 16'h0);
      arrive = 3'b100; tick(); arrive = '0;
      chk("R6 exited warp arrival ignored", 64'(out_valid), 64'(0));
      arrive_all("R6 release with remaining warps", 0);
      post_event(1, 12'h000, 16'h0130, 16'h0120, 16'h0140, 16'h0);
      arrive = 3'b001; tick(); arrive = '0;
      chk("R6 waiting on warp 1", 64'(out_valid), 64'(0));
      exit_warp = 3'b010; tick(); exit_warp = '0; m_live[1] = 0;
      chk("R6 no release on exit edge", 64'(out_valid), 64'(0));
      tick();
      m_apply();
      chk("R6 exit completes barrier", 64'(out_valid), 64'(1));
      chk_top("R6 exit release");
      tick();
      chk("R8 single pulse", 64'(out_valid), 64'(0));
      exit_warp = 3'b001; tick(); exit_warp = '0; m_live[0] = 0;
      post_event(1, 12'hfff, 16'h0150, 16'h0144, 16'h0160, 16'h0);
      arrive = 3'b111; tick(); arrive = '0;
      tick(); tick();
      chk("R6 no release with no live warp", 64'(out_valid), 64'(0));
      chk("R6 top untouched", 64'(out_pc), 64'(m_pc[m_cnt-1]));

      // random phase
      for (int n = 0; n < 400; n++) begin
         logic          br;
         logic [PW-1:0] pc;
         if (n % 50 == 0) do_init(PW'($urandom & 32'h7fff), TH'(($urandom & 32'hfff) | 32'h1));
         br = 1'($urandom % 2);
         pc = ($urandom % 2 == 0) ? m_rpc[m_cnt-1] : PW'($urandom & 32'h7fff);
         post_event(br, TH'($urandom), PW'($urandom & 32'h7fff), PW'($urandom & 32'h7fff),
                    PW'($urandom & 32'h7fff), pc);
         arrive_all(br ? "R4 random branch" : "R5 random reconvergence", int'($urandom % NW));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule